// File: doc/BRIEF.md
# Partition-Indexed Direct-Mapped Data Cache

This block is a direct-mapped data cache whose set is supplied from outside. A separate translation stage can force some of the top index bits of an address to fixed values. The cache receives that transformed set number with each request, next to the untouched word address. Forcing bits lets software cut the cache into independent regions, each sized as a power of two. Each region then behaves as a smaller cache of its own. Conflicts between data streams placed in different regions disappear.

When a top index bit is forced, the set number no longer shows the original value of that bit. For this reason, the stored tag keeps the address tag together with the original top index bits. A hit needs a valid line and a match on this extended tag. Read misses fetch the whole line from backing memory, one word per cycle, and then answer. Writes always go through to memory. A write updates the cached copy only when it hits, so a write miss allocates no line. A flush input drops every line at once. Software uses it after changing the partition layout.

Top module: `part_cache`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, mem_rd_en and mem_wr_en are 0. Every line is invalid, so the first read of any address misses.
- R2: A read miss asserts mem_rd_en for exactly LINE_WORDS consecutive cycles. The addresses run upward from the line base, which is the word address with its low log2(LINE_WORDS) bits cleared. The miss then responds with resp_hit=0 and the requested word.
- R3: A read hit responds with resp_valid=1, resp_hit=1 and the stored word on the first rising edge after the edge that accepted it. It issues no memory read. resp_valid is a single-cycle pulse.
- R4: The stored tag holds the address tag plus the original top FIX_W index bits. Two addresses that differ only in those bits, steered into the same set, never hit on each other's line.
- R5: Every write produces exactly one mem_wr_en pulse. The pulse carries the request address and data and comes on the same edge as the write's response.
- R6: A write miss answers with resp_hit=0 and starts no line fetch. A later read of that address misses and returns the written word from memory.
- R7: A write hit answers with resp_hit=1 and updates the cached word. A later read hits and returns the new word.
- R8: A one-cycle flush pulse invalidates every line. A flush in the same cycle as an accepted request makes that lookup miss.
- R9: The req_set input alone selects the set. Lines placed in different sets through req_set stay resident at the same time.
- R10: req_ready is 0 from the edge that accepts a request until its response. It is 1 again in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Original word address |
| req_set | input | SET_W | Transformed set index |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Idle, request can be taken |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_rdata | output | DATA_W | Read data |
| mem_rd_en | output | 1 | Backing memory read strobe |
| mem_rd_addr | output | ADDR_W | Backing memory read address |
| mem_rd_valid | input | 1 | Read data valid, one cycle after the strobe |
| mem_rd_data | input | DATA_W | Read data from memory |
| mem_wr_en | output | 1 | Backing memory write strobe |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |

## Verification
Reads are tried in several forms. A cold line tells a fill apart from a hit. Another word of a just-filled line must hit without fetching. A second address is then forced into an occupied set, with the same address tag and only the top index bits differing. Only the extended tag can report that case as a miss, and the returning first address must miss again. A line in a separately forced region must survive all of this. Writes are tried as hits and as misses, and the data read back afterwards separates the update-on-hit path from no-allocate. Flush is tried alone and in the same cycle as a request.

// File: rtl/part_cache_pkg.sv
package part_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } pc_state_e;
endpackage

// File: rtl/pc_tag_store.sv
module pc_tag_store #(
  parameter int SET_W  = 8,
  parameter int ETAG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [SET_W-1:0]  rd_set,
  output logic [ETAG_W-1:0] rd_tag,
  output logic              rd_valid,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [ETAG_W-1:0] wr_tag
);
  localparam int SETS = 1 << SET_W;

  logic [ETAG_W-1:0] tags [SETS];
  logic [SETS-1:0]   valid;

  // tag array: plain synchronous RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_set] <= wr_tag;
    rd_tag <= tags[rd_set];
  end

  // valid bits in flops so a flush clears them in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= valid[rd_set] & ~flush;
      if (flush)      valid         <= '0;
      else if (wr_en) valid[wr_set] <= 1'b1;
    end
  end
endmodule

// File: rtl/pc_data_store.sv
module pc_data_store #(
  parameter int AW     = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/part_cache.sv
module part_cache #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int CACHE_WORDS = 1024,
  parameter int LINE_WORDS  = 4,
  parameter int FIX_W       = 2,
  localparam int OFF_W      = $clog2(LINE_WORDS),
  localparam int SET_W      = $clog2(CACHE_WORDS / LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SET_W-1:0]  req_set,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  import part_cache_pkg::*;

  // extended tag = address tag plus the original top FIX_W index bits
  localparam int ETAG_W = ADDR_W - OFF_W - SET_W + FIX_W;
  localparam int DA_W   = SET_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST_WORD  = OFF_W'(LINE_WORDS - 1);
  localparam logic [OFF_W:0]   ISSUE_DONE = (OFF_W+1)'(LINE_WORDS);

  pc_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [SET_W-1:0]  set_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [OFF_W:0]    iss_cnt;
  logic [OFF_W-1:0]  ret_cnt;
  logic [DATA_W-1:0] word_q;

  logic              accept, hit, fill_last;
  logic [ETAG_W-1:0] look_tag, cur_etag;
  logic              look_valid;
  logic [DATA_W-1:0] look_data;
  logic              d_we;
  logic [DA_W-1:0]   d_waddr;
  logic [DATA_W-1:0] d_wdata;
  logic [OFF_W-1:0]  off_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign off_q     = addr_q[OFF_W-1:0];
  assign cur_etag  = addr_q[ADDR_W-1 -: ETAG_W];
  assign hit       = look_valid && (look_tag == cur_etag);
  assign fill_last = (state == ST_FILL) && mem_rd_valid && (ret_cnt == LAST_WORD);

  pc_tag_store #(.SET_W(SET_W), .ETAG_W(ETAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .rd_set   (req_set),
    .rd_tag   (look_tag),
    .rd_valid (look_valid),
    .wr_en    (fill_last),
    .wr_set   (set_q),
    .wr_tag   (cur_etag)
  );

  // data RAM write port: write hit in lookup, or refill word
  always_comb begin
    d_we    = 1'b0;
    d_waddr = {set_q, off_q};
    d_wdata = wdata_q;
    if (state == ST_LOOK && wr_q && hit) begin
      d_we = 1'b1;
    end else if (state == ST_FILL && mem_rd_valid) begin
      d_we    = 1'b1;
      d_waddr = {set_q, ret_cnt};
      d_wdata = mem_rd_data;
    end
  end

  pc_data_store #(.AW(DA_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .we    (d_we),
    .waddr (d_waddr),
    .wdata (d_wdata),
    .raddr ({req_set, req_addr[OFF_W-1:0]}),
    .rdata (look_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      set_q       <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      iss_cnt     <= '0;
      ret_cnt     <= '0;
      word_q      <= '0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_rdata  <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_wr_en  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            set_q   <= req_set;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            state   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (wr_q) begin
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= addr_q;
            mem_wr_data <= wdata_q;
            resp_valid  <= 1'b1;
            resp_hit    <= hit;
            state       <= ST_IDLE;
          end else if (hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_rdata <= look_data;
            state      <= ST_IDLE;
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            iss_cnt     <= (OFF_W+1)'(1);
            ret_cnt     <= '0;
            state       <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rd_en) begin
            if (iss_cnt == ISSUE_DONE) begin
              mem_rd_en <= 1'b0;
            end else begin
              mem_rd_addr <= mem_rd_addr + ADDR_W'(1);
              iss_cnt     <= iss_cnt + (OFF_W+1)'(1);
            end
          end
          if (mem_rd_valid) begin
            ret_cnt <= ret_cnt + OFF_W'(1);
            if (ret_cnt == off_q) word_q <= mem_rd_data;
            if (ret_cnt == LAST_WORD) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b0;
              resp_rdata <= (off_q == LAST_WORD) ? mem_rd_data : word_q;
              state      <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/part_cache_chk.sv
module part_cache_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_en
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!resp_valid && !mem_rd_en && !mem_wr_en && req_ready)); // R1

  AST_FILL_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(1))); // R2

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R3

  AST_WR_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> resp_valid); // R5

  AST_NO_FILL_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !mem_rd_en); // R6

  AST_BUSY_DURING_FILL: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready); // R10

  AST_READY_AT_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready); // R10
endmodule

bind part_cache part_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_en   (mem_wr_en)
);

// File: tb/part_cache_bench.sv
module part_cache_bench;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SET_W  = 8;
  localparam int LINE   = 4;
  localparam int MEMD   = 1 << ADDR_W;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [SET_W-1:0]  set;
    logic [DATA_W-1:0] wdata;
    logic              exp_hit;
    logic [15:0]       tag;
  } vec_t;

  // address = {tag[1:0], index[7:0], offset[1:0]}
  localparam vec_t VEC [12] = '{
    '{1'b0, 12'h449, 8'h12, 32'h0,         1'b0, "R2"},  // cold miss
    '{1'b0, 12'h449, 8'h12, 32'h0,         1'b1, "R3"},  // same word hits
    '{1'b0, 12'h44B, 8'h12, 32'h0,         1'b1, "R3"},  // other word of line
    '{1'b0, 12'h648, 8'h12, 32'h0,         1'b0, "R4"},  // top bits forced
    '{1'b0, 12'h449, 8'h12, 32'h0,         1'b0, "R4"},  // evicted
    '{1'b0, 12'h902, 8'hC0, 32'h0,         1'b0, "R9"},  // other region
    '{1'b0, 12'h902, 8'hC0, 32'h0,         1'b1, "R9"},
    '{1'b0, 12'h449, 8'h12, 32'h0,         1'b1, "R9"},  // both resident
    '{1'b1, 12'h449, 8'h12, 32'h12345678,  1'b1, "R7"},  // write hit
    '{1'b0, 12'h449, 8'h12, 32'h0,         1'b1, "R7"},
    '{1'b1, 12'hC14, 8'h05, 32'hCAFEF00D,  1'b0, "R6"},  // write miss
    '{1'b0, 12'hC14, 8'h05, 32'h0,         1'b0, "R6"}   // no allocate
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [SET_W-1:0]  req_set = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [DATA_W-1:0] resp_rdata;
  logic mem_rd_en, mem_wr_en;
  logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
  logic [DATA_W-1:0] mem_wr_data;
  logic mem_rd_valid = 1'b0;
  logic [DATA_W-1:0] mem_rd_data = '0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  part_cache u_part_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_set(req_set), .req_wdata(req_wdata),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_rdata(resp_rdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  function automatic logic [DATA_W-1:0] seed(input int i);
    return 32'hA5000000 ^ (i * 32'h00010101);
  endfunction

  // backing memory model and bus monitor
  logic [DATA_W-1:0] bmem [MEMD];
  logic [DATA_W-1:0] ref_mem [MEMD];
  logic [ADDR_W-1:0] rd_log [16];
  int rd_cnt = 0, wr_cnt = 0;
  logic [ADDR_W-1:0] last_wr_addr = '0;
  logic [DATA_W-1:0] last_wr_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEMD; i++) bmem[i] <= seed(i);
      mem_rd_valid <= 1'b0;
    end else begin
      mem_rd_valid <= mem_rd_en;
      if (mem_rd_en) begin
        mem_rd_data <= bmem[mem_rd_addr];
        rd_log[rd_cnt % 16] <= mem_rd_addr;
        rd_cnt <= rd_cnt + 1;
      end
      if (mem_wr_en) begin
        bmem[mem_wr_addr] <= mem_wr_data;
        last_wr_addr <= mem_wr_addr;
        last_wr_data <= mem_wr_data;
        wr_cnt <= wr_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [SET_W-1:0] s, input logic [DATA_W-1:0] d,
                        input logic fl, output logic hit, output logic [DATA_W-1:0] q,
                        output int lat, output int rdd, output int wrd, output int rd0,
                        output bit busy_bad);
    int wr0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_set = s; req_wdata = d;
    flush = fl;
    rd0 = rd_cnt; wr0 = wr_cnt; busy_bad = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; flush = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 100) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      lat++;
    end
    hit = resp_hit; q = resp_rdata;
    if (!req_ready) busy_bad = 1'b1;
    @(negedge clk);
    rdd = rd_cnt - rd0; wrd = wr_cnt - wr0;
  endtask

  task automatic run_read(input logic [ADDR_W-1:0] a, input logic [SET_W-1:0] s,
                          input logic fl, input logic exp_hit, input string rq);
    logic h; logic [DATA_W-1:0] q; int lat, rdd, wrd, rd0; bit bb;
    do_req(1'b0, a, s, '0, fl, h, q, lat, rdd, wrd, rd0, bb);
    check(lat < 100, rq, "response timeout", 32'(lat), 32'd0);
    check(h == exp_hit, rq, "hit flag", 32'(h), 32'(exp_hit));
    check(q == ref_mem[a], rq, "read data", q, ref_mem[a]);
    check(!bb, "R10", "req_ready while busy", 32'(bb), 32'd0);
    if (exp_hit) begin
      check(rdd == 0, "R3", "memory reads on hit", 32'(rdd), 32'd0);
      check(lat == 1, "R3", "hit latency", 32'(lat), 32'd1);
    end else begin
      check(rdd == LINE, "R2", "refill word count", 32'(rdd), 32'(LINE));
      for (int k = 0; k < LINE; k++)
        check(rd_log[(rd0 + k) % 16] == ((a & ~12'(LINE - 1)) + 12'(k)), "R2",
              "refill address", 32'(rd_log[(rd0 + k) % 16]),
              32'((a & ~12'(LINE - 1)) + 12'(k)));
    end
  endtask

  task automatic run_write(input logic [ADDR_W-1:0] a, input logic [SET_W-1:0] s,
                           input logic [DATA_W-1:0] d, input logic exp_hit, input string rq);
    logic h; logic [DATA_W-1:0] q; int lat, rdd, wrd, rd0; bit bb;
    do_req(1'b1, a, s, d, 1'b0, h, q, lat, rdd, wrd, rd0, bb);
    ref_mem[a] = d;
    check(h == exp_hit, rq, "write hit flag", 32'(h), 32'(exp_hit));
    check(wrd == 1, "R5", "write-through count", 32'(wrd), 32'd1);
    check(last_wr_addr == a, "R5", "write-through addr", 32'(last_wr_addr), 32'(a));
    check(last_wr_data == d, "R5", "write-through data", last_wr_data, d);
    check(lat == 1, "R5", "write response latency", 32'(lat), 32'd1);
    check(rdd == 0, "R6", "reads during write", 32'(rdd), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < MEMD; i++) ref_mem[i] = seed(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
    check(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
    check(mem_rd_en == 1'b0, "R1", "mem_rd_en after reset", 32'(mem_rd_en), 32'd0);
    check(mem_wr_en == 1'b0, "R1", "mem_wr_en after reset", 32'(mem_wr_en), 32'd0);

    for (int v = 0; v < 12; v++) begin
      string rq;
      rq = $sformatf("%s", VEC[v].tag);
      if (VEC[v].wr) run_write(VEC[v].addr, VEC[v].set, VEC[v].wdata, VEC[v].exp_hit, rq);
      else           run_read(VEC[v].addr, VEC[v].set, 1'b0, VEC[v].exp_hit, rq);
    end

    // R8: lone flush pulse drops resident lines
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    run_read(12'h902, 8'hC0, 1'b0, 1'b0, "R8");
    run_read(12'h902, 8'hC0, 1'b0, 1'b1, "R8");
    // R8: flush in the accept cycle forces a miss
    run_read(12'h902, 8'hC0, 1'b1, 1'b0, "R8");
    // R1: an address never touched still misses
    run_read(12'h000, 8'h00, 1'b0, 1'b0, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule